// File: doc/BRIEF.md
# Register-Controlled Signal Crosspoint Switch

This block is the routing fabric of an eight-port telecom framer test setup. Every framer port has eight equipment-side signals that need a driver: signalling input, serial data input, transmit superframe sync, transmit system clock, receive system clock, transmit clock, receive sync and transmit sync. For each of these 64 outputs, a host-written selector picks the driver. The choices are the matching source signal of any of the eight ports, a T1-rate or E1-rate clock, a fast 16.384 MHz clock, a constant level, or high impedance. The two system-clock outputs can also take a backplane clock.

A global register sets the sources for two line-interface master clocks and a reference clock. Each can be 1.544 MHz, 2.048 MHz or off. Fixed identification and revision values can be read over the same bus.

The host bus is synchronous and single-cycle. A write is sampled on a rising clock edge. A read returns data in the same cycle as its address. The selectors are registered, but the routing paths are combinational, so the oscillator and peer signals pass through without being resampled. Each output comes with an enable that a pad ring turns into high impedance. While an enable is low, the data bit beside it is held at 0.

Top module: `xpr_router`

## Requirements
- R1: The selector for port n (1 to 8) and signal k (0 to 7) sits at address 16·n + k. The signal order is: 0 signalling, 1 serial data, 2 superframe sync, 3 transmit system clock, 4 receive system clock, 5 transmit clock, 6 receive sync, 7 transmit sync. Its routed output is bit (n−1)·8 + k of `route_out`/`route_oe`. A write with `bus_we` high is stored at the rising edge, and a read of the address returns the stored value in the same cycle.
- R2: Reserved selector bits are kept at zero and read back as zero. These are bits 7:4 for signals 0 to 6, bits 7:5 for signal 7, and bits 7:6 of the global clock register.
- R3: After reset, every routed output is disabled and the global clock register reads 0x2A.
- R4: In a 4-bit selector, codes 1 to 8 drive the output, with its enable high, from the source of port 1 to 8. The sources per signal are, in signal order: `rx_sig`, `rx_ser`, `rx_msync`, `rx_chblk`, `tx_chblk`, `tx_clk_in`, `tx_sync_in`.
- R5: Code 0xA drives `osc_t1`, 0xB drives `osc_e1`, 0xC drives `osc_fast`, 0xD drives constant 0 and 0xE drives constant 1, each with the enable high.
- R6: Codes 0x0 and 0xF disable the output. Code 0x9 selects `bp_clk` for signals 3 and 4 only, and disables every other output. A disabled output drives data 0.
- R7: The transmit-sync selector is 5 bits wide. Codes 0x01 to 0x08 take `rx_sync` of ports 1 to 8, and codes 0x11 to 0x18 take `rx_msync` of ports 1 to 8. Codes 0x0A to 0x0E act as in R5. Every other code disables the output.
- R8: The global clock register is at 0x90. Bits 1:0 drive `gclk_out[0]` (master A), bits 3:2 drive `gclk_out[1]` (master B) and bits 5:4 drive `gclk_out[2]` (reference). In each field, 01 selects `osc_1544`, 10 selects `osc_2048`, and 00 or 11 disables the output.
- R9: The identification reads are: 0x00 returns 0x0D, 0x02 returns 0x00, 0x03 returns 0x01 and 0x04 returns 0x06. Addresses 0x05, 0x06 and 0x07 return the fab, assembly and firmware revision parameters.
- R10: Every other address reads 0. A write to such an address, or to an identification address, changes no register and no output.
- R11: A new selector value takes effect on the routing at the rising edge that samples the write. Before that edge, the output still follows the old selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, same cycle |
| rx_sig | input | NPORTS | Per-port receive signalling sources |
| rx_ser | input | NPORTS | Per-port receive serial data sources |
| rx_msync | input | NPORTS | Per-port receive multiframe sync sources |
| rx_chblk | input | NPORTS | Per-port receive channel-block sources |
| tx_chblk | input | NPORTS | Per-port transmit channel-block sources |
| tx_clk_in | input | NPORTS | Per-port transmit clock sources |
| tx_sync_in | input | NPORTS | Per-port transmit sync sources |
| rx_sync | input | NPORTS | Per-port receive sync sources |
| osc_t1 | input | 1 | T1-rate clock |
| osc_e1 | input | 1 | E1-rate clock |
| osc_fast | input | 1 | 16.384 MHz clock |
| bp_clk | input | 1 | Backplane clock |
| osc_1544 | input | 1 | 1.544 MHz clock for global outputs |
| osc_2048 | input | 1 | 2.048 MHz clock for global outputs |
| route_out | output | NPORTS*8 | Routed data, bit (n−1)·8 + k |
| route_oe | output | NPORTS*8 | Output enables matching `route_out` |
| gclk_out | output | 3 | Master A, master B and reference clock data |
| gclk_oe | output | 3 | Enables for `gclk_out` |

## Verification
A corrupted selector register shows up on two paths in the cycle after the faulty edge. The read of its address returns the wrong value, and its output follows the wrong source or changes enable. Because the routing is combinational, a decode error in a multiplexer is visible as soon as the source inputs toggle, with no register in between. Random source patterns are therefore applied to every output while each selector is held, so that a wrong port or code is caught at once. A write that lands on the wrong address, or on an address that should not be writable, is exposed by the full readback sweep and by comparing all 64 enables against the model after each write.

// File: rtl/xpr_pkg.sv
`timescale 1ns/1ps
package xpr_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NSIG     = 8;      // routed signal kinds per port
    localparam int SEL_W    = 5;      // widest selector (transmit sync)
    localparam int NARROW_W = 4;      // selector width of the other signals
    localparam int GFLD_W   = 2;
    localparam int NGCLK    = 3;
    localparam int SIG_TSYS = 3;
    localparam int SIG_RSYS = 4;
    localparam int SIG_SYNC = 7;

    localparam logic [NARROW_W-1:0] C_BP   = 4'h9;
    localparam logic [NARROW_W-1:0] C_T1   = 4'hA;
    localparam logic [NARROW_W-1:0] C_E1   = 4'hB;
    localparam logic [NARROW_W-1:0] C_FAST = 4'hC;
    localparam logic [NARROW_W-1:0] C_LO   = 4'hD;
    localparam logic [NARROW_W-1:0] C_HI   = 4'hE;

    localparam logic [GFLD_W-1:0] G_1544 = 2'b01;
    localparam logic [GFLD_W-1:0] G_2048 = 2'b10;

    localparam logic [ADDR_W-1:0] A_BOARD = 8'h00;
    localparam logic [ADDR_W-1:0] A_XH    = 8'h02;
    localparam logic [ADDR_W-1:0] A_XM    = 8'h03;
    localparam logic [ADDR_W-1:0] A_XL    = 8'h04;
    localparam logic [ADDR_W-1:0] A_FAB   = 8'h05;
    localparam logic [ADDR_W-1:0] A_ASSY  = 8'h06;
    localparam logic [ADDR_W-1:0] A_FW    = 8'h07;
    localparam logic [ADDR_W-1:0] A_GCLK  = 8'h90;

    localparam logic [DATA_W-1:0] ID_BOARD = 8'h0D;
    localparam logic [DATA_W-1:0] ID_XH    = 8'h00;
    localparam logic [DATA_W-1:0] ID_XM    = 8'h01;
    localparam logic [DATA_W-1:0] ID_XL    = 8'h06;

    // port is zero-based here; the bus sees port+1 in the upper nibble
    function automatic logic [ADDR_W-1:0] ctl_addr(int port, int sig);
        return ADDR_W'((port + 1) * 16 + sig);
    endfunction
endpackage

// File: rtl/xpr_regfile.sv
`timescale 1ns/1ps
module xpr_regfile
    import xpr_pkg::*;
#(
    parameter int              NPORTS   = 8,
    parameter logic [DATA_W-1:0] REV_FAB  = 8'h01,
    parameter logic [DATA_W-1:0] REV_ASSY = 8'h02,
    parameter logic [DATA_W-1:0] REV_FW   = 8'h03
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic                                we,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic [NPORTS*NSIG-1:0][SEL_W-1:0]   sel,
    output logic [NGCLK*GFLD_W-1:0]             gsel
);
    localparam int NSEL = NPORTS * NSIG;
    localparam int GW   = NGCLK * GFLD_W;
    localparam logic [SEL_W-1:0] WIDE_MASK   = '1;
    localparam logic [SEL_W-1:0] NARROW_MASK = SEL_W'((1 << NARROW_W) - 1);

    typedef struct packed {
        logic [NSEL-1:0][SEL_W-1:0] sel;
        logic [GW-1:0]              gsel;
    } regs_t;

    localparam regs_t RESET_VAL = '{sel: '0, gsel: {NGCLK{G_2048}}};

    regs_t r_q, r_d;

    always_comb begin
        r_d   = r_q;
        rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int s = 0; s < NSIG; s++) begin
                if (addr == ctl_addr(p, s)) begin
                    rdata = DATA_W'(r_q.sel[p*NSIG+s]);
                    if (we) begin
                        r_d.sel[p*NSIG+s] = wdata[SEL_W-1:0] &
                            ((s == SIG_SYNC) ? WIDE_MASK : NARROW_MASK);
                    end
                end
            end
        end
        if (addr == A_GCLK) begin
            rdata = DATA_W'(r_q.gsel);
            if (we) begin
                r_d.gsel = wdata[GW-1:0];
            end
        end
        case (addr)
            A_BOARD: rdata = ID_BOARD;
            A_XH:    rdata = ID_XH;
            A_XM:    rdata = ID_XM;
            A_XL:    rdata = ID_XL;
            A_FAB:   rdata = REV_FAB;
            A_ASSY:  rdata = REV_ASSY;
            A_FW:    rdata = REV_FW;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel  = r_q.sel;
    assign gsel = r_q.gsel;
endmodule

// File: rtl/xpr_src_mux.sv
`timescale 1ns/1ps
module xpr_src_mux
    import xpr_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter bit HAS_BP = 1'b0
) (
    input  logic [SEL_W-1:0]  code,
    input  logic [NPORTS-1:0] peer,
    input  logic              bp,
    input  logic              t1,
    input  logic              e1,
    input  logic              fast,
    output logic              out,
    output logic              oe
);
    always_comb begin
        out = 1'b0;
        oe  = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (code == SEL_W'(i + 1)) begin
                out = peer[i];
                oe  = 1'b1;
            end
        end
        case (code)
            {1'b0, C_BP}: begin
                if (HAS_BP) begin
                    out = bp;
                    oe  = 1'b1;
                end
            end
            {1'b0, C_T1}:   begin out = t1;   oe = 1'b1; end
            {1'b0, C_E1}:   begin out = e1;   oe = 1'b1; end
            {1'b0, C_FAST}: begin out = fast; oe = 1'b1; end
            {1'b0, C_LO}:   begin out = 1'b0; oe = 1'b1; end
            {1'b0, C_HI}:   begin out = 1'b1; oe = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/xpr_sync_mux.sv
`timescale 1ns/1ps
module xpr_sync_mux
    import xpr_pkg::*;
#(
    parameter int NPORTS = 8
) (
    input  logic [SEL_W-1:0]  code,
    input  logic [NPORTS-1:0] peer_lo,
    input  logic [NPORTS-1:0] peer_hi,
    input  logic              t1,
    input  logic              e1,
    input  logic              fast,
    output logic              out,
    output logic              oe
);
    logic lo_out, lo_oe;

    xpr_src_mux #(.NPORTS(NPORTS), .HAS_BP(1'b0)) u_lo (
        .code (code),
        .peer (peer_lo),
        .bp   (1'b0),
        .t1   (t1),
        .e1   (e1),
        .fast (fast),
        .out  (lo_out),
        .oe   (lo_oe)
    );

    always_comb begin
        out = lo_out;
        oe  = lo_oe;
        for (int i = 0; i < NPORTS; i++) begin
            if (code == {1'b1, NARROW_W'(i + 1)}) begin
                out = peer_hi[i];
                oe  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xpr_gclk_sel.sv
`timescale 1ns/1ps
module xpr_gclk_sel
    import xpr_pkg::*;
(
    input  logic [GFLD_W-1:0] field,
    input  logic              c1544,
    input  logic              c2048,
    output logic              out,
    output logic              oe
);
    always_comb begin
        out = 1'b0;
        oe  = 1'b0;
        case (field)
            G_1544: begin out = c1544; oe = 1'b1; end
            G_2048: begin out = c2048; oe = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/xpr_router.sv
`timescale 1ns/1ps
module xpr_router
    import xpr_pkg::*;
#(
    parameter int                NPORTS   = 8,
    parameter logic [DATA_W-1:0] REV_FAB  = 8'h01,
    parameter logic [DATA_W-1:0] REV_ASSY = 8'h02,
    parameter logic [DATA_W-1:0] REV_FW   = 8'h03
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NPORTS-1:0]        rx_sig,
    input  logic [NPORTS-1:0]        rx_ser,
    input  logic [NPORTS-1:0]        rx_msync,
    input  logic [NPORTS-1:0]        rx_chblk,
    input  logic [NPORTS-1:0]        tx_chblk,
    input  logic [NPORTS-1:0]        tx_clk_in,
    input  logic [NPORTS-1:0]        tx_sync_in,
    input  logic [NPORTS-1:0]        rx_sync,
    input  logic                     osc_t1,
    input  logic                     osc_e1,
    input  logic                     osc_fast,
    input  logic                     bp_clk,
    input  logic                     osc_1544,
    input  logic                     osc_2048,
    output logic [NPORTS*NSIG-1:0]   route_out,
    output logic [NPORTS*NSIG-1:0]   route_oe,
    output logic [NGCLK-1:0]         gclk_out,
    output logic [NGCLK-1:0]         gclk_oe
);
    logic [NPORTS*NSIG-1:0][SEL_W-1:0] sel_q;
    logic [NGCLK*GFLD_W-1:0]           gsel_q;
    logic [NSIG-1:0][NPORTS-1:0]       fam;

    assign fam[0] = rx_sig;
    assign fam[1] = rx_ser;
    assign fam[2] = rx_msync;
    assign fam[3] = rx_chblk;
    assign fam[4] = tx_chblk;
    assign fam[5] = tx_clk_in;
    assign fam[6] = tx_sync_in;
    assign fam[7] = rx_sync;

    xpr_regfile #(
        .NPORTS   (NPORTS),
        .REV_FAB  (REV_FAB),
        .REV_ASSY (REV_ASSY),
        .REV_FW   (REV_FW)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .sel   (sel_q),
        .gsel  (gsel_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        for (genvar s = 0; s < NSIG; s++) begin : g_sig
            localparam int IDX = p * NSIG + s;
            if (s == SIG_SYNC) begin : g_sync
                xpr_sync_mux #(.NPORTS(NPORTS)) u_mux (
                    .code    (sel_q[IDX]),
                    .peer_lo (fam[s]),
                    .peer_hi (rx_msync),
                    .t1      (osc_t1),
                    .e1      (osc_e1),
                    .fast    (osc_fast),
                    .out     (route_out[IDX]),
                    .oe      (route_oe[IDX])
                );
            end else begin : g_plain
                xpr_src_mux #(
                    .NPORTS (NPORTS),
                    .HAS_BP (s == SIG_TSYS || s == SIG_RSYS)
                ) u_mux (
                    .code (sel_q[IDX]),
                    .peer (fam[s]),
                    .bp   (bp_clk),
                    .t1   (osc_t1),
                    .e1   (osc_e1),
                    .fast (osc_fast),
                    .out  (route_out[IDX]),
                    .oe   (route_oe[IDX])
                );
            end
        end
    end

    for (genvar g = 0; g < NGCLK; g++) begin : g_gclk
        xpr_gclk_sel u_sel (
            .field (gsel_q[g*GFLD_W +: GFLD_W]),
            .c1544 (osc_1544),
            .c2048 (osc_2048),
            .out   (gclk_out[g]),
            .oe    (gclk_oe[g])
        );
    end
endmodule

// File: rtl/xpr_router_chk.sv
`timescale 1ns/1ps
module xpr_router_chk
    import xpr_pkg::*;
#(
    parameter int NPORTS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NPORTS*NSIG-1:0] route_out,
    input logic [NPORTS*NSIG-1:0] route_oe,
    input logic [NGCLK-1:0]       gclk_out,
    input logic [NGCLK-1:0]       gclk_oe
);
    function automatic logic port_hit(logic [ADDR_W-1:0] a);
        return (a[7:4] >= 4'd1) && (a[7:4] <= 4'(NPORTS)) && !a[3];
    endfunction

    function automatic logic [NGCLK-1:0] fields_on(logic [DATA_W-1:0] d);
        logic [NGCLK-1:0] on;
        for (int k = 0; k < NGCLK; k++) begin
            on[k] = (d[k*GFLD_W +: GFLD_W] == G_1544) ||
                    (d[k*GFLD_W +: GFLD_W] == G_2048);
        end
        return on;
    endfunction

    // R6: a disabled output carries data 0
    a_r6_tri_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((route_out & ~route_oe) == '0) && ((gclk_out & ~gclk_oe) == '0));

    // R2: narrow selectors read back with bits 7:4 clear
    a_r2_narrow_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit(bus_addr) && bus_addr[2:0] != 3'd7) |-> (bus_rdata[7:4] == 4'd0));

    // R2: transmit-sync selector reads back with bits 7:5 clear
    a_r2_sync_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit(bus_addr) && bus_addr[2:0] == 3'd7) |-> (bus_rdata[7:5] == 3'd0));

    // R9: board identification value
    a_r9_board_id: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_BOARD) |-> (bus_rdata == ID_BOARD));

    // R8: global enables agree with the global register contents
    a_r8_gclk_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_GCLK) |-> (gclk_oe == fields_on(bus_rdata) && bus_rdata[7:6] == 2'd0));

    // R11: a global write shows on the enables after the sampling edge
    a_r11_gclk_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_GCLK) |=> (gclk_oe == fields_on($past(bus_wdata))));

    // R10: writes to unmapped or read-only addresses leave every enable alone
    a_r10_unmapped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !port_hit(bus_addr) && bus_addr != A_GCLK) |=>
        ($stable(route_oe) && $stable(gclk_oe)));
endmodule

bind xpr_router xpr_router_chk #(.NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .route_out (route_out),
    .route_oe  (route_oe),
    .gclk_out  (gclk_out),
    .gclk_oe   (gclk_oe)
);

// File: tb/xpr_router_bench.sv
`timescale 1ns/1ps
module xpr_router_bench;
    import xpr_pkg::*;

    localparam int NP = 8;
    localparam int NO = NP * NSIG;
    localparam logic [7:0] RF = 8'h01, RA = 8'h02, RW = 8'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NP-1:0] rx_sig = '0, rx_ser = '0, rx_msync = '0, rx_chblk = '0;
    logic [NP-1:0] tx_chblk = '0, tx_clk_in = '0, tx_sync_in = '0, rx_sync = '0;
    logic osc_t1 = 1'b0, osc_e1 = 1'b0, osc_fast = 1'b0, bp_clk = 1'b0;
    logic osc_1544 = 1'b0, osc_2048 = 1'b0;
    logic [NO-1:0] route_out, route_oe;
    logic [2:0] gclk_out, gclk_oe;

    always #4 clk = ~clk;

    xpr_router #(.NPORTS(NP), .REV_FAB(RF), .REV_ASSY(RA), .REV_FW(RW)) u_xpr_router (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_sig(rx_sig), .rx_ser(rx_ser), .rx_msync(rx_msync), .rx_chblk(rx_chblk),
        .tx_chblk(tx_chblk), .tx_clk_in(tx_clk_in), .tx_sync_in(tx_sync_in),
        .rx_sync(rx_sync), .osc_t1(osc_t1), .osc_e1(osc_e1), .osc_fast(osc_fast),
        .bp_clk(bp_clk), .osc_1544(osc_1544), .osc_2048(osc_2048),
        .route_out(route_out), .route_oe(route_oe),
        .gclk_out(gclk_out), .gclk_oe(gclk_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [4:0] sh [NO];
    logic [5:0] gsh;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] family(int s);
        case (s)
            0: return rx_sig;
            1: return rx_ser;
            2: return rx_msync;
            3: return rx_chblk;
            4: return tx_chblk;
            5: return tx_clk_in;
            6: return tx_sync_in;
            default: return rx_sync;
        endcase
    endfunction

    // {oe, out} expected for output p*8+s
    function automatic logic [1:0] exp_route(int p, int s);
        int c = int'(sh[p*NSIG+s]);
        logic [NP-1:0] f = family(s);
        for (int i = 0; i < NP; i++) begin
            if (c == i + 1) return {1'b1, f[i]};
            if (s == 7 && c == 17 + i) return {1'b1, rx_msync[i]};
        end
        case (c)
            9:  if (s == 3 || s == 4) return {1'b1, bp_clk};
            10: return {1'b1, osc_t1};
            11: return {1'b1, osc_e1};
            12: return {1'b1, osc_fast};
            13: return 2'b10;
            14: return 2'b11;
            default: ;
        endcase
        return 2'b00;
    endfunction

    function automatic string req_of(int s, int c);
        if (s == 7) return "R7";
        if (c >= 1 && c <= 8) return "R4";
        if (c >= 10 && c <= 14) return "R5";
        return "R6";
    endfunction

    function automatic logic [1:0] exp_gclk(int k);
        case (gsh[2*k +: 2])
            2'b01: return {1'b1, osc_1544};
            2'b10: return {1'b1, osc_2048};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NSIG; s++)
                if (a == 8'((p + 1) * 16 + s)) return {3'b000, sh[p*NSIG+s]};
        case (a)
            8'h90: return {2'b00, gsh};
            8'h00: return 8'h0D;
            8'h02: return 8'h00;
            8'h03: return 8'h01;
            8'h04: return 8'h06;
            8'h05: return RF;
            8'h06: return RA;
            8'h07: return RW;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(logic [7:0] a, logic [7:0] d);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NSIG; s++)
                if (a == 8'((p + 1) * 16 + s))
                    sh[p*NSIG+s] = (s == 7) ? d[4:0] : {1'b0, d[3:0]};
        if (a == 8'h90) gsh = d[5:0];
    endfunction

    task automatic shuffle_sources();
        rx_sig = NP'($urandom); rx_ser = NP'($urandom); rx_msync = NP'($urandom);
        rx_chblk = NP'($urandom); tx_chblk = NP'($urandom); tx_clk_in = NP'($urandom);
        tx_sync_in = NP'($urandom); rx_sync = NP'($urandom);
        osc_t1 = 1'($urandom); osc_e1 = 1'($urandom); osc_fast = 1'($urandom);
        bp_clk = 1'($urandom); osc_1544 = 1'($urandom); osc_2048 = 1'($urandom);
        #1;
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
        #1;
    endtask

    task automatic read_check(logic [7:0] a, string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a), $sformatf("read addr %h", a));
    endtask

    task automatic check_one(int p, int s);
        int c = int'(sh[p*NSIG+s]);
        check(req_of(s, c), {6'd0, route_oe[p*NSIG+s], route_out[p*NSIG+s]},
              {6'd0, exp_route(p, s)}, $sformatf("port %0d sig %0d code %h", p + 1, s, c));
    endtask

    task automatic check_all(string gtag);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < NSIG; s++) check_one(p, s);
        for (int k = 0; k < 3; k++)
            check(gtag, {6'd0, gclk_oe[k], gclk_out[k]}, {6'd0, exp_gclk(k)},
                  $sformatf("global clock %0d", k));
    endtask

    task automatic sweep_reads(string tag);
        for (int a = 0; a < 256; a++) read_check(8'(a), tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < NO; i++) sh[i] = '0;
        gsh = 6'h2A;

        // R3: reset state
        repeat (3) @(negedge clk);
        shuffle_sources();
        check("R3", {7'd0, |route_oe}, 8'd0, "enables during reset");
        rst_n = 1'b1;
        @(negedge clk);
        read_check(8'h90, "R3");
        for (int r = 0; r < 4; r++) begin
            shuffle_sources();
            check_all("R3");
        end

        // R9 / R10: identification and empty addresses
        sweep_reads("R9");

        // R11: timing of a selector update (port 1, serial data, code 0xE)
        @(negedge clk);
        bus_addr = 8'h11; bus_wdata = 8'h0E; bus_we = 1'b1;
        #1;
        check("R11", {7'd0, route_oe[1]}, 8'd0, "before sampling edge");
        @(negedge clk);
        bus_we = 1'b0;
        model_write(8'h11, 8'h0E);
        #1;
        check("R11", {6'd0, route_oe[1], route_out[1]}, 8'd3, "after sampling edge");

        // directed sweep of every code for each signal kind
        for (int s = 0; s < NSIG; s++) begin
            int p = (s * 3) % NP;
            int ncode = (s == 7) ? 32 : 16;
            for (int c = 0; c < ncode; c++) begin
                bus_write(8'((p + 1) * 16 + s), 8'(c) | ((s == 7) ? 8'hE0 : 8'hF0));
                read_check(8'((p + 1) * 16 + s), "R2");
                for (int r = 0; r < 3; r++) begin
                    shuffle_sources();
                    check_one(p, s);
                end
            end
        end

        // R8: each global field value
        for (int v = 0; v < 64; v++) begin
            bus_write(8'h90, 8'(v) | 8'hC0);
            read_check(8'h90, "R8");
            for (int r = 0; r < 2; r++) begin
                shuffle_sources();
                check_all("R8");
            end
        end

        // random writes mixed across valid and arbitrary addresses
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            if ($urandom_range(0, 9) < 7)
                a = 8'(($urandom_range(1, NP) * 16) + $urandom_range(0, 7));
            else
                a = 8'($urandom);
            bus_write(a, 8'($urandom));
            read_check(a, "R1");
            shuffle_sources();
            check_all("R8");
        end

        // R10: writes to read-only and empty addresses change nothing
        begin
            logic [7:0] bad [12] = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h07, 8'h08,
                                     8'h0F, 8'h18, 8'h8F, 8'h91, 8'hA0, 8'hFF};
            for (int i = 0; i < 12; i++) begin
                bus_write(bad[i], 8'hFF);
                read_check(bad[i], "R10");
                shuffle_sources();
                check_all("R10");
            end
        end
        sweep_reads("R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule